// File: doc/BRIEF.md
# Fully Associative Address Translation Buffer with Shared-Page Matching

This block caches virtual-to-physical page translations in a small, fully associative array. Each unified entry holds a valid flag, a virtual page number, an 8-bit address-space identifier, a shared flag, a dirty flag and a physical page number. A second, smaller array of instruction entries is kept next to it. That array holds only the match fields and a valid flag. It exists so that a software update of the mappings can also invalidate stale instruction-side translations.

Three operations are provided. A lookup compares a virtual page number against all unified entries. One cycle later it reports a miss, a single hit (with a one-hot vector, the physical page number and the dirty flag of the entry), or a multiple hit. A load writes one unified entry from staging inputs at the slot named by a replacement counter. Only lookups advance that counter. An associative write searches both arrays with one page number and rewrites the dirty and valid flags of every matching entry. It flags a multiple-hit exception or a required instruction-side flush when either applies.

Address-space comparison is skipped for entries marked shared. It is also skipped for all entries when the single-space control input is set and the processor runs privileged.

Top module: `assoc_tlb`

## Requirements
- R1: An entry whose valid flag is 0 never matches, either on a lookup or on an associative write.
- R2: An entry matches when its page number equals the key page number and either its identifier equals the key identifier or its shared flag is 1.
- R3: When `single_vspace` is 1 and `priv_mode` is 1, the identifier is ignored for every entry. In all other combinations it is compared as in R2.
- R4: One cycle after `lk_req`, exactly one of `lk_hit`, `lk_miss`, `lk_multi` is 1. `lk_multi` is set for two or more matches. On `lk_hit`, `lk_hit_vec` has only the matching entry's bit set, and `lk_ppn` and `lk_dirty` give that entry's fields. Without a lookup, all three result flags and `lk_hit_vec` are 0.
- R5: The replacement index `repl_idx` is 0 after reset. It advances by one, modulo UTLB_N, on each cycle with `lk_req`. Nothing else changes it, and a load in particular does not.
- R6: `ld_req` writes page number, identifier, shared, dirty, valid and physical page from the staging inputs into unified entry `repl_idx`. `ild_req` writes page number, identifier, shared and valid into instruction entry `ild_idx`.
- R7: The associative-write word `aw_data` carries the dirty flag in bit 9, the valid flag in bit 8 and the identifier in bits 7:0. When at most one unified entry matches, each matching unified entry takes the new dirty and valid flags, and each matching instruction entry takes the new valid flag.
- R8: An associative write that matches two or more unified entries raises `aw_multi` one cycle later with `exc_code` = 0x140 and updates no entry. Otherwise `aw_multi` is 0 and `exc_code` is 0.
- R9: `flush_req` is 1 one cycle after an associative write that updates at least one matching valid instruction entry with a written valid flag of 0. It is 0 otherwise.
- R10: Synchronous reset clears every valid flag in both arrays and all result outputs, so every lookup after reset misses.
- R11: When `aw_req` is asserted, any `ld_req` or `ild_req` in the same cycle is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| priv_mode | input | 1 | 1 = privileged execution |
| single_vspace | input | 1 | 1 = one shared virtual space for privileged code |
| cur_asid | input | ASID_W | Current address-space identifier used by lookups |
| lk_req | input | 1 | Lookup strobe |
| lk_vpn | input | VPN_W | Lookup page number |
| lk_hit | output | 1 | Single match |
| lk_miss | output | 1 | No match |
| lk_multi | output | 1 | Two or more matches |
| lk_hit_vec | output | UTLB_N | One-hot index of the hit |
| lk_ppn | output | PPN_W | Physical page of the hit entry |
| lk_dirty | output | 1 | Dirty flag of the hit entry |
| repl_idx | output | log2(UTLB_N) | Replacement index used by loads |
| ld_req | input | 1 | Load unified entry at `repl_idx` |
| ild_req | input | 1 | Load instruction entry at `ild_idx` |
| ild_idx | input | log2(ITLB_N) | Instruction entry slot |
| stg_vpn | input | VPN_W | Staging page number |
| stg_asid | input | ASID_W | Staging identifier |
| stg_shared | input | 1 | Staging shared flag |
| stg_dirty | input | 1 | Staging dirty flag |
| stg_valid | input | 1 | Staging valid flag |
| stg_ppn | input | PPN_W | Staging physical page |
| aw_req | input | 1 | Associative write strobe |
| aw_vpn | input | VPN_W | Associative write page number |
| aw_data | input | ASID_W+2 | {dirty, valid, identifier} |
| aw_multi | output | 1 | Multiple-hit exception on associative write |
| exc_code | output | 12 | Exception code, 0x140 with `aw_multi` |
| flush_req | output | 1 | Instruction-side flush required |

## Verification
Page numbers and identifiers are drawn from pools of eight and four values, so random loads often create duplicates, identifier mismatches and shared entries. These expose single hits, multiple hits and misses that differ only in the identifier rule. Privileged mode and the single-space control are randomized on every operation, which separates the skipped-identifier case from the two cases where it is still compared. Directed steps place an invalid twin of a live entry, a shared entry probed with a foreign identifier, a duplicated page that must make an associative write abort, and a shared instruction entry that an invalidating write must flush. Loads between lookups show that only lookups move the replacement index.

// File: rtl/assoc_tlb_pkg.sv
package assoc_tlb_pkg;
  localparam int EXC_W = 12;
  localparam logic [EXC_W-1:0] MULTI_HIT_CODE = 12'h140;

  typedef enum logic [1:0] {RES_NONE, RES_ONE, RES_MANY} res_e;

  function automatic res_e classify(input int n);
    if (n == 0) return RES_NONE;
    if (n == 1) return RES_ONE;
    return RES_MANY;
  endfunction
endpackage

// File: rtl/tlb_cam_match.sv
module tlb_cam_match #(
  parameter int N      = 64,
  parameter int VPN_W  = 20,
  parameter int ASID_W = 8
) (
  input  logic [N-1:0]             ent_v,
  input  logic [N-1:0]             ent_sh,
  input  logic [N-1:0][VPN_W-1:0]  ent_vpn,
  input  logic [N-1:0][ASID_W-1:0] ent_asid,
  input  logic [VPN_W-1:0]         key_vpn,
  input  logic [ASID_W-1:0]        key_asid,
  input  logic                     use_asid,
  output logic [N-1:0]             hits
);
  for (genvar g = 0; g < N; g++) begin : g_ent
    logic vpn_eq, asid_ok;
    assign vpn_eq  = (ent_vpn[g] == key_vpn);
    assign asid_ok = !use_asid || ent_sh[g] || (ent_asid[g] == key_asid);
    assign hits[g] = ent_v[g] && vpn_eq && asid_ok;
  end
endmodule

// File: rtl/tlb_repl_ctr.sv
module tlb_repl_ctr #(
  parameter int N = 64,
  localparam int W = (N > 1) ? $clog2(N) : 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         step,
  output logic [W-1:0] idx
);
  always_ff @(posedge clk) begin
    if (rst)
      idx <= '0;
    else if (step)
      idx <= (idx == W'(N - 1)) ? '0 : idx + 1'b1;
  end
endmodule

// File: rtl/assoc_tlb.sv
module assoc_tlb
  import assoc_tlb_pkg::*;
#(
  parameter int UTLB_N = 64,
  parameter int ITLB_N = 4,
  parameter int VPN_W  = 20,
  parameter int PPN_W  = 20,
  parameter int ASID_W = 8,
  localparam int IDX_W  = (UTLB_N > 1) ? $clog2(UTLB_N) : 1,
  localparam int IIDX_W = (ITLB_N > 1) ? $clog2(ITLB_N) : 1,
  localparam int AWD_W  = ASID_W + 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              priv_mode,
  input  logic              single_vspace,
  input  logic [ASID_W-1:0] cur_asid,
  input  logic              lk_req,
  input  logic [VPN_W-1:0]  lk_vpn,
  output logic              lk_hit,
  output logic              lk_miss,
  output logic              lk_multi,
  output logic [UTLB_N-1:0] lk_hit_vec,
  output logic [PPN_W-1:0]  lk_ppn,
  output logic              lk_dirty,
  output logic [IDX_W-1:0]  repl_idx,
  input  logic              ld_req,
  input  logic              ild_req,
  input  logic [IIDX_W-1:0] ild_idx,
  input  logic [VPN_W-1:0]  stg_vpn,
  input  logic [ASID_W-1:0] stg_asid,
  input  logic              stg_shared,
  input  logic              stg_dirty,
  input  logic              stg_valid,
  input  logic [PPN_W-1:0]  stg_ppn,
  input  logic              aw_req,
  input  logic [VPN_W-1:0]  aw_vpn,
  input  logic [AWD_W-1:0]  aw_data,
  output logic              aw_multi,
  output logic [EXC_W-1:0]  exc_code,
  output logic              flush_req
);
  localparam int D_POS = ASID_W + 1;
  localparam int V_POS = ASID_W;

  // unified array: flags and match fields in registers, page numbers in a RAM
  logic [UTLB_N-1:0]             u_v, u_sh, u_d;
  logic [UTLB_N-1:0][VPN_W-1:0]  u_vpn;
  logic [UTLB_N-1:0][ASID_W-1:0] u_asid;
  logic [PPN_W-1:0]              u_ppn [UTLB_N];

  // instruction array
  logic [ITLB_N-1:0]             i_v, i_sh;
  logic [ITLB_N-1:0][VPN_W-1:0]  i_vpn;
  logic [ITLB_N-1:0][ASID_W-1:0] i_asid;

  logic              use_asid;
  logic [UTLB_N-1:0] lk_match, aw_umatch;
  logic [ITLB_N-1:0] aw_imatch;
  res_e              lk_res, aw_res;
  logic [IDX_W-1:0]  lk_enc;
  logic              aw_commit, ld_we, ild_we;

  assign use_asid  = !(single_vspace && priv_mode);
  assign ld_we     = ld_req && !aw_req;
  assign ild_we    = ild_req && !aw_req;
  assign lk_res    = classify($countones(lk_match));
  assign aw_res    = classify($countones(aw_umatch));
  assign aw_commit = aw_req && (aw_res != RES_MANY);

  tlb_cam_match #(.N(UTLB_N), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_lk_cam (
    .ent_v(u_v), .ent_sh(u_sh), .ent_vpn(u_vpn), .ent_asid(u_asid),
    .key_vpn(lk_vpn), .key_asid(cur_asid), .use_asid(use_asid),
    .hits(lk_match)
  );

  tlb_cam_match #(.N(UTLB_N), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_aw_cam (
    .ent_v(u_v), .ent_sh(u_sh), .ent_vpn(u_vpn), .ent_asid(u_asid),
    .key_vpn(aw_vpn), .key_asid(aw_data[ASID_W-1:0]), .use_asid(use_asid),
    .hits(aw_umatch)
  );

  tlb_cam_match #(.N(ITLB_N), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_iw_cam (
    .ent_v(i_v), .ent_sh(i_sh), .ent_vpn(i_vpn), .ent_asid(i_asid),
    .key_vpn(aw_vpn), .key_asid(aw_data[ASID_W-1:0]), .use_asid(use_asid),
    .hits(aw_imatch)
  );

  tlb_repl_ctr #(.N(UTLB_N)) u_repl (
    .clk(clk), .rst(rst), .step(lk_req), .idx(repl_idx)
  );

  always_comb begin
    lk_enc = '0;
    for (int i = 0; i < UTLB_N; i++)
      if (lk_match[i]) lk_enc = IDX_W'(i);
  end

  // valid flags: the only array state under reset
  always_ff @(posedge clk) begin
    if (rst) begin
      u_v <= '0;
      i_v <= '0;
    end else if (aw_commit) begin
      for (int i = 0; i < UTLB_N; i++)
        if (aw_umatch[i]) u_v[i] <= aw_data[V_POS];
      for (int j = 0; j < ITLB_N; j++)
        if (aw_imatch[j]) i_v[j] <= aw_data[V_POS];
    end else begin
      if (ld_we)  u_v[repl_idx] <= stg_valid;
      if (ild_we) i_v[ild_idx]  <= stg_valid;
    end
  end

  // match fields and dirty flags
  always_ff @(posedge clk) begin
    if (aw_commit) begin
      for (int i = 0; i < UTLB_N; i++)
        if (aw_umatch[i]) u_d[i] <= aw_data[D_POS];
    end
    if (ld_we) begin
      u_vpn[repl_idx]  <= stg_vpn;
      u_asid[repl_idx] <= stg_asid;
      u_sh[repl_idx]   <= stg_shared;
      u_d[repl_idx]    <= stg_dirty;
    end
    if (ild_we) begin
      i_vpn[ild_idx]  <= stg_vpn;
      i_asid[ild_idx] <= stg_asid;
      i_sh[ild_idx]   <= stg_shared;
    end
  end

  // physical page RAM: synchronous write, registered read
  always_ff @(posedge clk) begin
    if (ld_we) u_ppn[repl_idx] <= stg_ppn;
    lk_ppn <= u_ppn[lk_enc];
  end

  // registered results
  always_ff @(posedge clk) begin
    if (rst) begin
      lk_hit     <= 1'b0;
      lk_miss    <= 1'b0;
      lk_multi   <= 1'b0;
      lk_hit_vec <= '0;
      lk_dirty   <= 1'b0;
      aw_multi   <= 1'b0;
      exc_code   <= '0;
      flush_req  <= 1'b0;
    end else begin
      lk_hit     <= lk_req && (lk_res == RES_ONE);
      lk_miss    <= lk_req && (lk_res == RES_NONE);
      lk_multi   <= lk_req && (lk_res == RES_MANY);
      lk_hit_vec <= (lk_req && lk_res == RES_ONE) ? lk_match : '0;
      lk_dirty   <= lk_req && (lk_res == RES_ONE) && u_d[lk_enc];
      aw_multi   <= aw_req && (aw_res == RES_MANY);
      exc_code   <= (aw_req && aw_res == RES_MANY) ? MULTI_HIT_CODE : '0;
      flush_req  <= aw_commit && (|aw_imatch) && !aw_data[V_POS];
    end
  end
endmodule

// File: rtl/assoc_tlb_chk.sv
module assoc_tlb_chk
  import assoc_tlb_pkg::*;
#(
  parameter int UTLB_N = 64,
  localparam int IDX_W = (UTLB_N > 1) ? $clog2(UTLB_N) : 1
) (
  input logic              clk,
  input logic              rst,
  input logic              lk_req,
  input logic              aw_req,
  input logic              lk_hit,
  input logic              lk_miss,
  input logic              lk_multi,
  input logic [UTLB_N-1:0] lk_hit_vec,
  input logic [IDX_W-1:0]  repl_idx,
  input logic              aw_multi,
  input logic [EXC_W-1:0]  exc_code,
  input logic              flush_req
);
  // R4
  res_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({lk_hit, lk_miss, lk_multi}));
  // R4
  res_given_chk: assert property (@(posedge clk) disable iff (rst)
    lk_req |=> (lk_hit || lk_miss || lk_multi));
  // R4
  res_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !lk_req |=> !(lk_hit || lk_miss || lk_multi));
  // R4
  hit_vec_chk: assert property (@(posedge clk) disable iff (rst)
    lk_hit |-> $countones(lk_hit_vec) == 1);
  // R4
  hit_vec_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !lk_hit |-> lk_hit_vec == '0);
  // R5
  repl_step_chk: assert property (@(posedge clk) disable iff (rst)
    lk_req |=> repl_idx == (($past(repl_idx) == IDX_W'(UTLB_N - 1)) ? '0 : $past(repl_idx) + 1'b1));
  // R5
  repl_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !lk_req |=> $stable(repl_idx));
  // R5
  repl_reset_chk: assert property (@(posedge clk)
    rst |=> repl_idx == '0);
  // R8
  exc_code_chk: assert property (@(posedge clk) disable iff (rst)
    aw_multi |-> exc_code == MULTI_HIT_CODE);
  // R8
  exc_clear_chk: assert property (@(posedge clk) disable iff (rst)
    !aw_multi |-> exc_code == '0);
  // R8
  aw_multi_src_chk: assert property (@(posedge clk) disable iff (rst)
    !aw_req |=> !aw_multi);
  // R9
  flush_src_chk: assert property (@(posedge clk) disable iff (rst)
    !aw_req |=> !flush_req);
  // R9
  flush_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(flush_req && aw_multi));
endmodule

bind assoc_tlb assoc_tlb_chk #(.UTLB_N(UTLB_N)) u_chk (
  .clk(clk), .rst(rst), .lk_req(lk_req), .aw_req(aw_req),
  .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_multi(lk_multi),
  .lk_hit_vec(lk_hit_vec), .repl_idx(repl_idx), .aw_multi(aw_multi),
  .exc_code(exc_code), .flush_req(flush_req)
);

// File: tb/assoc_tlb_test.sv
module assoc_tlb_test;
  localparam int CLK_P = 10;
  localparam int UN = 64;
  localparam int IN = 4;
  localparam int VW = 20;
  localparam int PW = 20;
  localparam int AW = 8;

  logic clk = 0;
  logic rst = 1;
  logic priv_mode = 0, single_vspace = 0;
  logic [AW-1:0] cur_asid = 0;
  logic lk_req = 0;
  logic [VW-1:0] lk_vpn = 0;
  logic lk_hit, lk_miss, lk_multi, lk_dirty;
  logic [UN-1:0] lk_hit_vec;
  logic [PW-1:0] lk_ppn;
  logic [5:0] repl_idx;
  logic ld_req = 0, ild_req = 0;
  logic [1:0] ild_idx = 0;
  logic [VW-1:0] stg_vpn = 0;
  logic [AW-1:0] stg_asid = 0;
  logic stg_shared = 0, stg_dirty = 0, stg_valid = 0;
  logic [PW-1:0] stg_ppn = 0;
  logic aw_req = 0;
  logic [VW-1:0] aw_vpn = 0;
  logic [AW+1:0] aw_data = 0;
  logic aw_multi, flush_req;
  logic [11:0] exc_code;

  int checks = 0;
  int errors = 0;

  // reference state
  bit          m_uv [UN], m_ush [UN], m_ud [UN];
  int unsigned m_uvpn [UN], m_uasid [UN], m_uppn [UN];
  bit          m_iv [IN], m_ish [IN];
  int unsigned m_ivpn [IN], m_iasid [IN];
  int          m_ctr = 0;

  always #(CLK_P/2) clk = ~clk;

  assoc_tlb uut (.*);

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic bit ref_match(bit v, int unsigned vpn, int unsigned asid, bit sh,
                                   int unsigned kvpn, int unsigned kasid, bit pm, bit sv);
    if (!v || vpn != kvpn) return 0;
    if (pm && sv) return 1;
    return sh || (asid == kasid);
  endfunction

  task automatic do_lookup(input int unsigned vpn, input int unsigned asid,
                           input bit pm, input bit sv, input string req);
    int n = 0, idx = 0;
    logic [UN-1:0] ev = '0;
    for (int i = 0; i < UN; i++)
      if (ref_match(m_uv[i], m_uvpn[i], m_uasid[i], m_ush[i], vpn, asid, pm, sv)) begin
        n++; idx = i;
      end
    if (n == 1) ev[idx] = 1'b1;
    lk_req = 1; lk_vpn = VW'(vpn); cur_asid = AW'(asid); priv_mode = pm; single_vspace = sv;
    @(posedge clk);
    m_ctr = (m_ctr + 1) % UN;
    @(negedge clk);
    lk_req = 0;
    chk(lk_hit == (n == 1), req, "R4 hit", 64'(lk_hit), 64'(n == 1));
    chk(lk_miss == (n == 0), req, "R4 miss", 64'(lk_miss), 64'(n == 0));
    chk(lk_multi == (n > 1), req, "R4 multi", 64'(lk_multi), 64'(n > 1));
    chk(lk_hit_vec == ev, req, "R4 hit_vec", lk_hit_vec, ev);
    if (n == 1) begin
      chk(lk_ppn == PW'(m_uppn[idx]), req, "R6 ppn", 64'(lk_ppn), 64'(m_uppn[idx]));
      chk(lk_dirty == m_ud[idx], req, "R7 dirty", 64'(lk_dirty), 64'(m_ud[idx]));
    end
    chk(repl_idx == 6'(m_ctr), "R5", "repl_idx after lookup", 64'(repl_idx), 64'(m_ctr));
  endtask

  task automatic do_load(input int unsigned vpn, input int unsigned asid, input bit sh,
                         input bit d, input bit v, input int unsigned ppn);
    stg_vpn = VW'(vpn); stg_asid = AW'(asid); stg_shared = sh; stg_dirty = d;
    stg_valid = v; stg_ppn = PW'(ppn); ld_req = 1;
    @(posedge clk);
    m_uv[m_ctr] = v; m_uvpn[m_ctr] = vpn; m_uasid[m_ctr] = asid; m_ush[m_ctr] = sh;
    m_ud[m_ctr] = d; m_uppn[m_ctr] = ppn;
    @(negedge clk);
    ld_req = 0;
    chk(repl_idx == 6'(m_ctr), "R5", "repl_idx after load", 64'(repl_idx), 64'(m_ctr));
  endtask

  task automatic do_iload(input int idx, input int unsigned vpn, input int unsigned asid,
                          input bit sh, input bit v);
    stg_vpn = VW'(vpn); stg_asid = AW'(asid); stg_shared = sh; stg_valid = v;
    ild_idx = 2'(idx); ild_req = 1;
    @(posedge clk);
    m_iv[idx] = v; m_ivpn[idx] = vpn; m_iasid[idx] = asid; m_ish[idx] = sh;
    @(negedge clk);
    ild_req = 0;
  endtask

  // R7 word layout: bit 9 dirty, bit 8 valid, bits 7:0 identifier
  task automatic do_aw(input int unsigned vpn, input bit d, input bit v, input int unsigned asid,
                       input bit pm, input bit sv, input bit with_ld, input string req);
    int n = 0;
    bit im = 0, exp_flush;
    bit um [UN];
    bit imv [IN];
    for (int i = 0; i < UN; i++) begin
      um[i] = ref_match(m_uv[i], m_uvpn[i], m_uasid[i], m_ush[i], vpn, asid, pm, sv);
      if (um[i]) n++;
    end
    for (int j = 0; j < IN; j++) begin
      imv[j] = ref_match(m_iv[j], m_ivpn[j], m_iasid[j], m_ish[j], vpn, asid, pm, sv);
      if (imv[j]) im = 1;
    end
    exp_flush = (n <= 1) && im && !v;
    aw_req = 1; aw_vpn = VW'(vpn); aw_data = {d, v, AW'(asid)};
    priv_mode = pm; single_vspace = sv;
    if (with_ld) begin  // R11: colliding load must be dropped
      stg_vpn = VW'(vpn); stg_asid = AW'(asid); stg_shared = 1; stg_dirty = 1;
      stg_valid = 1; stg_ppn = '1; ld_req = 1;
    end
    @(posedge clk);
    if (n <= 1) begin
      for (int i = 0; i < UN; i++) if (um[i]) begin m_uv[i] = v; m_ud[i] = d; end
      for (int j = 0; j < IN; j++) if (imv[j]) m_iv[j] = v;
    end
    @(negedge clk);
    aw_req = 0; ld_req = 0;
    chk(aw_multi == (n > 1), req, "R8 aw_multi", 64'(aw_multi), 64'(n > 1));
    chk(exc_code == ((n > 1) ? 12'h140 : 12'h000), req, "R8 exc_code", 64'(exc_code),
        (n > 1) ? 64'h140 : 64'h0);
    chk(flush_req == exp_flush, req, "R9 flush", 64'(flush_req), 64'(exp_flush));
  endtask

  // place an entry at the next slot by first moving the index with a lookup
  task automatic place(input int unsigned vpn, input int unsigned asid, input bit sh,
                       input bit d, input bit v, input int unsigned ppn);
    do_lookup(32'hFFFFF, 0, 0, 0, "R5");
    do_load(vpn, asid, sh, d, v, ppn);
  endtask

  initial begin
    #(CLK_P * 150000);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < UN; i++) m_uv[i] = 0;
    for (int j = 0; j < IN; j++) m_iv[j] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    // R10 reset state
    chk(repl_idx == 0, "R10", "repl_idx at reset", 64'(repl_idx), 0);
    chk(!lk_hit && !lk_miss && !lk_multi, "R10", "results at reset",
        64'({lk_hit, lk_miss, lk_multi}), 0);
    chk(!aw_multi && !flush_req && exc_code == 0, "R10", "aw outputs at reset",
        64'({aw_multi, flush_req}), 0);
    do_lookup(0, 0, 0, 0, "R10");

    // R6 load at index 1, load again: index unchanged (R5)
    do_load(32'h100, 5, 0, 0, 1, 32'hAAA);
    do_load(32'h100, 5, 0, 0, 1, 32'hABC);
    do_lookup(32'h100, 5, 0, 0, "R2");
    do_lookup(32'h100, 6, 0, 0, "R2");
    do_lookup(32'h100, 6, 1, 1, "R3");
    do_lookup(32'h100, 6, 0, 1, "R3");
    do_lookup(32'h100, 6, 1, 0, "R3");
    // shared entry matches any identifier
    place(32'h200, 1, 1, 0, 1, 32'h222);
    do_lookup(32'h200, 9, 0, 0, "R2");
    // invalid entry never matches
    place(32'h300, 3, 1, 0, 0, 32'h333);
    do_lookup(32'h300, 3, 0, 0, "R1");
    do_aw(32'h300, 1, 1, 3, 0, 0, 0, "R1");
    do_lookup(32'h300, 3, 0, 0, "R1");
    // duplicate page: multi on lookup and aborted associative write
    place(32'h100, 5, 0, 0, 1, 32'h111);
    do_lookup(32'h100, 5, 0, 0, "R4");
    do_aw(32'h100, 0, 0, 5, 0, 0, 0, "R8");
    do_lookup(32'h100, 5, 0, 0, "R8");
    // instruction side flush on invalidation of a shared page
    do_iload(2, 32'h200, 1, 1, 1);
    do_aw(32'h200, 1, 0, 7, 0, 0, 0, "R9");
    do_lookup(32'h200, 1, 0, 0, "R7");
    // dirty set through associative write, with a colliding load dropped
    place(32'h400, 2, 0, 0, 1, 32'h444);
    do_aw(32'h400, 1, 1, 2, 0, 0, 1, "R11");
    do_lookup(32'h400, 2, 0, 0, "R7");
    do_lookup(32'h400, 2, 0, 0, "R11");

    // constrained random phase
    void'($urandom(32'd1234));
    for (int k = 0; k < 1500; k++) begin
      int unsigned op = $urandom_range(0, 99);
      int unsigned vpn = $urandom_range(0, 7);
      int unsigned asid = $urandom_range(0, 3);
      bit pm = 1'($urandom_range(0, 1));
      bit sv = 1'($urandom_range(0, 1));
      bit sh = ($urandom_range(0, 3) == 0);
      bit v = ($urandom_range(0, 3) != 0);
      bit d = 1'($urandom_range(0, 1));
      if (op < 35)
        do_lookup(vpn, asid, pm, sv, "R2");
      else if (op < 60)
        do_load(vpn, asid, sh, d, v, $urandom_range(0, 32'hFFFFF));
      else if (op < 70)
        do_iload($urandom_range(0, IN - 1), vpn, asid, sh, v);
      else
        do_aw(vpn, d, v, asid, pm, sv, ($urandom_range(0, 7) == 0), "R7");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule